// File: doc/BRIEF.md
# Privilege-Gated Message FIFO

This block is a one-way queue that carries event records from a main processor to a monitoring co-processor. Each record pairs a 32-bit tag (for example a call-site number) with a 32-bit value (for example a branch target or a register snapshot). The processor side has a write port and nothing else. It cannot read, overwrite or withdraw an entry once the entry is queued. The monitor side drains the records with a valid/ready handshake, in the order they were written.

A write is accepted only while the processor's active-low management-mode indicator is asserted. The indicator passes through a two-flop synchronizer before it gates writes.

The block records misuse in two sticky flags, which are visible to the monitor:
- A write attempted outside management mode is dropped and sets the illegal-access flag.
- A write into a full queue is refused and sets the overflow flag.

A reset clears both flags. Occupancy, empty and full are given to the monitor side only. The data path is one register stage deep, so a record reaches the monitor one cycle after it is written.

Top module: `gated_msg_fifo`

## Requirements
- R1: Records leave the pop port in exactly the order in which they were accepted at the push port.
- R2: A push while the synchronized mode indicator is deasserted (high) is dropped. The queue contents and the occupancy are unchanged by it.
- R3: A dropped out-of-mode push sets `err_illegal`, which stays at 1 until reset. It does not set `err_overflow`.
- R4: A push while `full` is 1 is refused, even if a pop completes in the same cycle. It sets `err_overflow`, which stays at 1 until reset. The refused record never appears at the pop port.
- R5: `pop_valid` is 1 exactly when the queue is not empty. While `pop_valid` is 1 and `pop_ready` is 0, `pop_tag` and `pop_val` hold steady.
- R6: `mode_n` passes through two flops.
  - After `mode_n` falls, pushes are dropped at the next two rising edges and accepted from the third.
  - After `mode_n` rises, pushes are still accepted at the next two rising edges and dropped from the third.
- R7: `count` equals the number of stored records (0 to 16). `empty` is 1 when the count is 0, and `full` is 1 when the count is 16.
- R8: After reset the queue is empty, both error flags are 0, and the mode indicator is treated as deasserted.
- R9: A record accepted at a rising edge appears at `pop_tag`/`pop_val`, with `pop_valid` 1, right after that edge if the queue was empty.
- R10: If a push is accepted and a pop completes at the same edge, `count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_n | input | 1 | Active-low management-mode indicator, asynchronous to clk |
| push_valid | input | 1 | Processor offers a record this cycle |
| push_tag | input | 32 | Record tag |
| push_val | input | 32 | Record value |
| pop_valid | output | 1 | Head record is available |
| pop_ready | input | 1 | Monitor takes the head record |
| pop_tag | output | 32 | Head record tag |
| pop_val | output | 32 | Head record value |
| count | output | 5 | Number of stored records |
| empty | output | 1 | Queue holds no record |
| full | output | 1 | Queue holds 16 records |
| err_illegal | output | 1 | Sticky: a push was made outside management mode |
| err_overflow | output | 1 | Sticky: a push was made into a full queue |

## Verification
- **Pushes and pops:** the effect of an accepted push or a completed pop shows on `count`, `empty`, `full` and the pop port one rising edge later. Both sticky flags likewise rise one edge after the offending push.
- **Mode pin:** a change on `mode_n` only takes effect on the third rising edge after it, because of the two-flop synchronizer. The gate test holds `push_valid` across three edges and checks the count after the second edge and again after the third.
- **Timing of checks:** inputs change on falling edges, and every check samples on a falling edge. Each result is therefore read half a cycle after the rising edge that produced it.

// File: rtl/gated_msg_fifo.sv
module gated_msg_fifo #(
  parameter int TAG_W = 32,
  parameter int VAL_W = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_n,
  input  logic             push_valid,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [VAL_W-1:0] push_val,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [TAG_W-1:0] pop_tag,
  output logic [VAL_W-1:0] pop_val,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             err_illegal,
  output logic             err_overflow
);

  localparam int MSG_W = TAG_W + VAL_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [1:0]       mode_sync;
  logic             mode_ok;
  logic [MSG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_fire, rd_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_sync <= 2'b11;
    else        mode_sync <= {mode_sync[0], mode_n};

  assign mode_ok   = ~mode_sync[1];
  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign pop_valid = ~empty;
  assign wr_fire   = push_valid & mode_ok & ~full;
  assign rd_fire   = pop_valid & pop_ready;
  assign {pop_tag, pop_val} = mem[rd_ptr];

  always_ff @(posedge clk)
    if (wr_fire) mem[wr_ptr] <= {push_tag, push_val};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_illegal  <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      if (push_valid && !mode_ok)         err_illegal  <= 1'b1;
      if (push_valid && mode_ok && full)  err_overflow <= 1'b1;
    end

  // R2: a gated-off push never raises the occupancy
  a_r2_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !mode_ok) |=> (count <= $past(count)));

  // R3: illegal-access flag is sticky
  a_r3_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> err_illegal);

  // R4: overflow flag is sticky; a full queue stays full without a pop
  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_fire) |=> full);

  // R5: head record holds while the monitor stalls
  a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_tag) && $stable(pop_val)));

  // R7: flags and occupancy stay consistent
  a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}) && (count <= CNT_W'(DEPTH)));

endmodule

// File: tb/sim_gated_msg_fifo.sv
module sim_gated_msg_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_n = 1'b1;
  logic        push_valid = 1'b0;
  logic [31:0] push_tag = '0;
  logic [31:0] push_val = '0;
  logic        pop_ready = 1'b0;
  logic        pop_valid;
  logic [31:0] pop_tag, pop_val;
  logic [4:0]  count;
  logic        empty, full, err_illegal, err_overflow;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  gated_msg_fifo u0 (
    .clk(clk), .rst_n(rst_n), .mode_n(mode_n),
    .push_valid(push_valid), .push_tag(push_tag), .push_val(push_val),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_tag(pop_tag), .pop_val(pop_val),
    .count(count), .empty(empty), .full(full),
    .err_illegal(err_illegal), .err_overflow(err_overflow)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mode_n = 1'b1; push_valid = 1'b0; pop_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enter_mode();
    mode_n = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic push1(input logic [31:0] t, input logic [31:0] v);
    push_valid = 1'b1; push_tag = t; push_val = v;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [31:0] t, input logic [31:0] v);
    eq({req, " pop_valid"}, 64'(pop_valid), 64'd1);
    eq({req, " data"}, {pop_tag, pop_val}, {t, v});
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    eq("R8 count", 64'(count), 64'd0);
    eq("R8 empty/full", {62'd0, empty, full}, 64'b10);
    eq("R8 flags", {62'd0, err_illegal, err_overflow}, 64'd0);
    eq("R5 pop_valid empty", 64'(pop_valid), 64'd0);
    push1(32'h1, 32'h2);
    eq("R8 mode deasserted after reset", 64'(count), 64'd0);
  endtask

  task automatic t_order();
    do_reset();
    enter_mode();
    push1(32'h0000_0619, 32'h0fff_b804);
    eq("R9 one-cycle visibility", {pop_tag, pop_val}, {32'h0000_0619, 32'h0fff_b804});
    eq("R9 pop_valid", 64'(pop_valid), 64'd1);
    for (int i = 1; i < 5; i++) push1(32'h100 + i, 32'hA000_0000 ^ i);
    eq("R7 count 5", 64'(count), 64'd5);
    pop_chk("R1 first", 32'h0000_0619, 32'h0fff_b804);
    for (int i = 1; i < 5; i++) pop_chk("R1 order", 32'h100 + i, 32'hA000_0000 ^ i);
    eq("R7 empty after drain", {62'd0, empty, pop_valid}, 64'b10);
    eq("R3 no spurious flags", {62'd0, err_illegal, err_overflow}, 64'd0);
  endtask

  task automatic t_gate();
    do_reset();
    push1(32'hBAD, 32'hBAD);
    eq("R2 dropped push count", 64'(count), 64'd0);
    eq("R3 illegal set, overflow clear", {62'd0, err_illegal, err_overflow}, 64'b10);
    push1(32'h5, 32'h5);
    eq("R3 illegal sticky", 64'(err_illegal), 64'd1);
    do_reset();
    mode_n = 1'b0; push_valid = 1'b1; push_tag = 32'h77; push_val = 32'h88;
    @(negedge clk); @(negedge clk);
    eq("R6 fall: dropped at first two edges", 64'(count), 64'd0);
    @(negedge clk);
    eq("R6 fall: accepted at third edge", 64'(count), 64'd1);
    push_valid = 1'b0;
    @(negedge clk);
    mode_n = 1'b1; push_valid = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    push_valid = 1'b0;
    eq("R6 rise: two more accepted", 64'(count), 64'd3);
    pop_chk("R1 gate head", 32'h77, 32'h88);
  endtask

  task automatic t_full();
    do_reset();
    enter_mode();
    for (int i = 0; i < 16; i++) push1(32'h200 + i, ~(32'h200 + i));
    eq("R7 full at 16", {58'd0, count, empty, full}, {58'd0, 5'd16, 1'b0, 1'b1});
    eq("R4 no overflow yet", 64'(err_overflow), 64'd0);
    push1(32'hDEAD, 32'hBEEF);
    eq("R4 overflow set", {62'd0, err_illegal, err_overflow}, 64'b01);
    eq("R4 count held", 64'(count), 64'd16);
    push_valid = 1'b1; push_tag = 32'hDEAD; push_val = 32'hBEEF; pop_ready = 1'b1;
    @(negedge clk);
    push_valid = 1'b0; pop_ready = 1'b0;
    eq("R4 refused even with pop", 64'(count), 64'd15);
    for (int i = 1; i < 16; i++) pop_chk("R4 contents", 32'h200 + i, ~(32'h200 + i));
    eq("R4 refused record absent", 64'(pop_valid), 64'd0);
    eq("R4 overflow sticky", 64'(err_overflow), 64'd1);
  endtask

  task automatic t_hold_simul();
    do_reset();
    enter_mode();
    push1(32'hA1, 32'hB1);
    push1(32'hA2, 32'hB2);
    @(negedge clk); @(negedge clk);
    eq("R5 head held while stalled", {pop_tag, pop_val}, {32'hA1, 32'hB1});
    push_valid = 1'b1; push_tag = 32'hA3; push_val = 32'hB3; pop_ready = 1'b1;
    @(negedge clk);
    push_valid = 1'b0; pop_ready = 1'b0;
    eq("R10 count unchanged", 64'(count), 64'd2);
    pop_chk("R10 head advanced", 32'hA2, 32'hB2);
    pop_chk("R10 new tail", 32'hA3, 32'hB3);
    eq("R7 empty", 64'(empty), 64'd1);
  endtask

  initial begin
    t_reset();
    t_order();
    t_gate();
    t_full();
    t_hold_simul();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule